// File: doc/BRIEF.md
# Mailbox I2C Master

This block is an I2C bus master that a host drives through four 16-bit registers instead of issuing byte-level commands. To start a transaction, the host does two writes. First it writes up to two outgoing bytes into the transmit-data register. Then it writes a command word that selects the target address, the direction, the length and whether the bus stays claimed afterwards. From that one command write, the engine runs the whole transaction on the wire: START, address byte, zero to two data bytes with acknowledge handling, and then either STOP or a held bus. It ends by raising exactly one of three sticky status flags. Received bytes appear in the receive-data register.

Holding the bus lets a register-address write chain into a following read. The held transaction leaves SCL low and sends no STOP, and the next command opens with a repeated START. The host side is a plain register port. A write takes effect in the cycle it is presented, a read returns data combinationally, and there is no flow control, so the port never stalls. The bus side is open-drain: `scl_o` is the clock level and `sda_oe` pulls SDA low.

Top module: `i2cmb_top`

## Requirements
- R1: Register offsets are 0 command, 1 transmit data, 2 receive data (read-only), 3 status. A command word starts a transaction only when its bits 15:14 equal 2'b10. Any other value is ignored and produces no bus activity.
- R2: Command bits 7:1 carry the 7-bit target address and bit 0 is ignored. The address byte on the bus is that address followed by a direction bit, 0 for write and 1 for read.
- R3: Command bit 10 set selects a write. Bit 11 set selects two data bytes, otherwise one. The byte in transmit-data bits 7:0 goes out first and bits 15:8 second. A fully acknowledged write ends by setting status bit 14.
- R4: With bit 10 clear, the master reads one or two bytes into receive-data bits 7:0 and then 15:8. It ACKs every received byte except the last, which it NAKs, and sets status bit 15.
- R5: Command bit 12 set makes an address-only probe that sends just the address byte. An acknowledge sets status bit 15 and a NAK sets bit 13.
- R6: A NAK on the address byte or on any written byte aborts the transaction with a STOP. It sets status bit 13 and neither completion flag.
- R7: Command bit 13 set holds the bus. After the last byte, no STOP is sent, SCL stays low and the completion flag is set. The next command begins with a repeated START.
- R8: Status bits 13, 14 and 15 are sticky and are cleared by writing 1 to them. A flag being set and a clear of that flag in the same cycle leaves the flag set.
- R9: Status bit 0 reads 1 from the cycle after a command is accepted until the cycle its completion flag appears. Command writes during that time are ignored, and so are changes to transmit data.
- R10: Each bus bit lasts four phases of DIV clocks each, so SCL rises every 4*DIV clocks within a transaction. SDA changes only while SCL is low, except inside START and STOP.
- R11: After reset, SCL is high, SDA is released and every status bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| sda_i | input | 1 | Sampled SDA line level |
| scl_o | output | 1 | SCL level driven by the master |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Two functions can fall in the same cycle: the sequencer setting a completion flag and a host write that clears that same flag. The bench provokes this by writing a clear of the transmit flag on every cycle while a write transaction runs, including the cycle in which busy drops. It judges the result by reading status afterwards and requiring the transmit flag to be set. A second overlap comes from a command write that arrives while a transaction is in flight. That case is judged at the bus: the slave model must see only the first transaction's bytes and a single START.

// File: rtl/i2cmb_pkg.sv
package i2cmb_pkg;
  localparam int REG_AW = 2;
  localparam int REG_DW = 16;
  localparam int BYTE_W = 8;

  localparam logic [REG_AW-1:0] OFS_CMD  = 2'd0;
  localparam logic [REG_AW-1:0] OFS_TXD  = 2'd1;
  localparam logic [REG_AW-1:0] OFS_RXD  = 2'd2;
  localparam logic [REG_AW-1:0] OFS_STAT = 2'd3;

  localparam int CB_WRITE = 10;
  localparam int CB_TWO   = 11;
  localparam int CB_AONLY = 12;
  localparam int CB_HOLD  = 13;
  localparam logic [1:0] CMD_KEY = 2'b10;

  localparam int SB_BUSY = 0;
  localparam int SB_ERR  = 13;
  localparam int SB_TX   = 14;
  localparam int SB_RX   = 15;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_START, SQ_BYTE, SQ_STOP, SQ_HELD
  } sq_state_e;

  typedef struct packed {
    logic [6:0] addr;
    logic       write;
    logic       two;
    logic       aonly;
    logic       hold;
  } cmd_t;
endpackage

// File: rtl/i2cmb_tick.sv
module i2cmb_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  a_r10_div_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < DIV);
endmodule

// File: rtl/i2cmb_regs.sv
module i2cmb_regs
  import i2cmb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  input  logic              busy,
  input  logic              fin_err,
  input  logic              fin_tx,
  input  logic              fin_rx,
  input  logic [REG_DW-1:0] rx_data,
  output logic              go,
  output cmd_t              cmd,
  output logic [REG_DW-1:0] txd
);
  logic [2:0] flags;   // {rx, tx, err}
  logic [2:0] set_v;
  logic [2:0] clr_v;

  assign go  = we && (addr == OFS_CMD) && (wdata[15:14] == CMD_KEY) && !busy;
  assign cmd = '{addr: wdata[7:1], write: wdata[CB_WRITE], two: wdata[CB_TWO],
                 aonly: wdata[CB_AONLY], hold: wdata[CB_HOLD]};

  assign set_v = {fin_rx, fin_tx, fin_err};
  assign clr_v = (we && addr == OFS_STAT) ? {wdata[SB_RX], wdata[SB_TX], wdata[SB_ERR]} : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      txd   <= '0;
    end else begin
      flags <= (flags & ~clr_v) | set_v;
      if (we && addr == OFS_TXD && !busy) txd <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_TXD:  rdata = txd;
      OFS_RXD:  rdata = rx_data;
      OFS_STAT: begin
        rdata[SB_BUSY] = busy;
        rdata[SB_ERR]  = flags[0];
        rdata[SB_TX]   = flags[1];
        rdata[SB_RX]   = flags[2];
      end
      default:  rdata = '0;
    endcase
  end

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((flags & $past(set_v)) == $past(set_v)));
endmodule

// File: rtl/i2cmb_seq.sv
module i2cmb_seq
  import i2cmb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              go,
  input  cmd_t              cmd,
  input  logic [REG_DW-1:0] txd,
  input  logic              sda_i,
  output logic              busy,
  output logic              fin_err,
  output logic              fin_tx,
  output logic              fin_rx,
  output logic [REG_DW-1:0] rx_data,
  output logic              scl_q,
  output logic              sda_oe_q
);
  sq_state_e         st;
  cmd_t              c;
  logic [REG_DW-1:0] wdat;
  logic [1:0]        ph;
  logic [3:0]        bitn;
  logic [1:0]        byten;
  logic [BYTE_W-1:0] sh;
  logic              samp;
  logic              err_q;
  logic              cond_q;
  logic [1:0]        nb;
  logic              tx_byte;
  logic              ack_bit;
  logic              nak_seen;
  logic              last_byte;
  logic              fin;
  logic              scl_n;
  logic              oe_n;

  assign nb        = c.aonly ? 2'd0 : (c.two ? 2'd2 : 2'd1);
  assign tx_byte   = (byten == 2'd0) || c.write;
  assign ack_bit   = (st == SQ_BYTE) && tick && (ph == 2'd3) && (bitn == 4'd8);
  assign nak_seen  = ack_bit && tx_byte && samp;
  assign last_byte = (byten == nb);
  assign busy      = (st == SQ_START) || (st == SQ_BYTE) || (st == SQ_STOP);

  assign fin = (tick && ph == 2'd3 && st == SQ_STOP) ||
               (ack_bit && !nak_seen && last_byte && c.hold);
  assign fin_err = fin && err_q;
  assign fin_tx  = fin && !err_q && c.write;
  assign fin_rx  = fin && !err_q && !c.write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      c       <= '0;
      wdat    <= '0;
      ph      <= '0;
      bitn    <= '0;
      byten   <= '0;
      sh      <= '0;
      samp    <= 1'b1;
      err_q   <= 1'b0;
      rx_data <= '0;
    end else if (go && (st == SQ_IDLE || st == SQ_HELD)) begin
      st    <= SQ_START;
      ph    <= '0;
      c     <= cmd;
      wdat  <= txd;
      err_q <= 1'b0;
    end else if (tick) begin
      case (st)
        SQ_START: begin
          ph <= ph + 2'd1;
          if (ph == 2'd3) begin
            st    <= SQ_BYTE;
            bitn  <= '0;
            byten <= '0;
            sh    <= {c.addr, !c.write};
          end
        end
        SQ_BYTE: begin
          ph <= ph + 2'd1;
          if (ph == 2'd1) samp <= sda_i;
          if (ph == 2'd3) begin
            if (bitn != 4'd8) begin
              sh   <= {sh[BYTE_W-2:0], samp};
              bitn <= bitn + 4'd1;
            end else if (nak_seen) begin
              err_q <= 1'b1;
              st    <= SQ_STOP;
            end else begin
              if (!tx_byte && byten == 2'd1) rx_data[7:0]  <= sh;
              if (!tx_byte && byten == 2'd2) rx_data[15:8] <= sh;
              if (last_byte) begin
                st <= c.hold ? SQ_HELD : SQ_STOP;
              end else begin
                byten <= byten + 2'd1;
                bitn  <= '0;
                sh    <= (byten == 2'd0) ? wdat[7:0] : wdat[15:8];
              end
            end
          end
        end
        SQ_STOP: begin
          ph <= ph + 2'd1;
          if (ph == 2'd3) st <= SQ_IDLE;
        end
        default: ;
      endcase
    end
  end

  // Line levels for the current phase; registered below so the pins never glitch.
  always_comb begin
    scl_n = 1'b1;
    oe_n  = 1'b0;
    case (st)
      SQ_HELD:  begin scl_n = 1'b0; oe_n = 1'b0; end
      SQ_START: begin scl_n = (ph == 2'd1) || (ph == 2'd2); oe_n = ph[1]; end
      SQ_STOP:  begin scl_n = (ph != 2'd0); oe_n = !ph[1]; end
      SQ_BYTE: begin
        scl_n = (ph == 2'd1) || (ph == 2'd2);
        if (bitn != 4'd8) oe_n = tx_byte && !sh[BYTE_W-1];
        else              oe_n = !tx_byte && !last_byte;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_oe_q <= 1'b0;
      cond_q   <= 1'b0;
    end else begin
      scl_q    <= scl_n;
      sda_oe_q <= oe_n;
      cond_q   <= (st == SQ_START) || (st == SQ_STOP);
    end
  end

  a_r10_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe_q != $past(sda_oe_q)) && !cond_q && !$past(cond_q)) |-> (!scl_q && !$past(scl_q)));

  a_r6_nak_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    nak_seen |=> (st == SQ_STOP && err_q));

  a_r7_held_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_HELD && $past(st) == SQ_HELD) |-> !scl_q);

  a_r9_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(c) && $stable(wdat)));

  a_r8_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fin_err, fin_tx, fin_rx}));
endmodule

// File: rtl/i2cmb_top.sv
module i2cmb_top
  import i2cmb_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              sda_i,
  output logic              scl_o,
  output logic              sda_oe
);
  logic              tick;
  logic              go;
  cmd_t              cmd;
  logic [REG_DW-1:0] txd;
  logic              busy;
  logic              fin_err;
  logic              fin_tx;
  logic              fin_rx;
  logic [REG_DW-1:0] rx_data;

  i2cmb_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  i2cmb_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .fin_err(fin_err), .fin_tx(fin_tx),
    .fin_rx(fin_rx), .rx_data(rx_data), .go(go), .cmd(cmd), .txd(txd)
  );

  i2cmb_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .cmd(cmd), .txd(txd),
    .sda_i(sda_i), .busy(busy), .fin_err(fin_err), .fin_tx(fin_tx),
    .fin_rx(fin_rx), .rx_data(rx_data), .scl_q(scl_o), .sda_oe_q(sda_oe)
  );

  a_r9_release_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(fin_err || fin_tx || fin_rx));
endmodule

// File: tb/i2cmb_top_tb_top.sv
`timescale 1ns/1ps
module i2cmb_top_tb_top;
  localparam int DIV = 4;
  localparam logic [6:0] SLV_ADDR = 7'h50;
  localparam logic [7:0] SLV_BASE = 8'hA5;

  typedef struct packed {
    logic        wr;
    logic        two;
    logic        aonly;
    logic [6:0]  addr;
    logic [15:0] wdat;
    logic [1:0]  nak_at;
    logic [2:0]  exp_fl;   // {rx, tx, err}
    logic [1:0]  exp_sent;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VT [NV] = '{
    '{1'b1, 1'b0, 1'b0, 7'h50, 16'h003C, 2'd3, 3'b010, 2'd1},
    '{1'b1, 1'b1, 1'b0, 7'h50, 16'hBEEF, 2'd3, 3'b010, 2'd2},
    '{1'b0, 1'b0, 1'b0, 7'h50, 16'h0000, 2'd3, 3'b100, 2'd0},
    '{1'b0, 1'b1, 1'b0, 7'h50, 16'h0000, 2'd3, 3'b100, 2'd0},
    '{1'b0, 1'b0, 1'b1, 7'h50, 16'h0000, 2'd3, 3'b100, 2'd0},
    '{1'b0, 1'b0, 1'b1, 7'h51, 16'h0000, 2'd3, 3'b001, 2'd0},
    '{1'b1, 1'b1, 1'b0, 7'h50, 16'hBEEF, 2'd1, 3'b001, 2'd2},
    '{1'b1, 1'b1, 1'b0, 7'h22, 16'hBEEF, 2'd3, 3'b001, 2'd0},
    '{1'b1, 1'b0, 1'b0, 7'h50, 16'h0077, 2'd0, 3'b001, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        scl_o;
  logic        sda_oe;
  logic        slv_low = 1'b0;
  wire         sda_line = !(sda_oe || slv_low);

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  i2cmb_top #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_i(sda_line),
    .scl_o(scl_o), .sda_oe(sda_oe)
  );

  // ---------------- slave model ----------------
  logic       pscl = 1'b1;
  logic       psda = 1'b1;
  logic       in_xfer = 1'b0;
  int         cnt = 0;
  logic       first = 1'b0;
  logic       sel = 1'b0;
  logic       rw = 1'b0;
  logic       ackit = 1'b0;
  logic       just_addr = 1'b0;
  logic       txm = 1'b0;
  logic       mlast = 1'b0;
  logic [7:0] sh_s = 8'd0;
  logic [7:0] tb_byte = 8'd0;
  int         tidx = 0;
  int         dn = 0;
  logic [1:0] nak_at = 2'd3;
  logic [7:0] wlog [8];
  int         wn = 0;
  logic [7:0] macks = 8'd0;
  int         starts = 0;
  int         stops = 0;
  int         reps = 0;
  longint     rise_t [4];
  int         rn = 0;

  always @(scl_o or sda_line) begin
    if (scl_o !== pscl) begin
      if (scl_o) begin
        if (rn < 4) begin rise_t[rn] = $time; rn++; end
        if (in_xfer) begin
          if (cnt < 8) begin
            if (!txm) sh_s = {sh_s[6:0], sda_line};
            cnt++;
            if (cnt == 8 && !txm) begin
              if (first) begin
                first = 1'b0; sel = (sh_s[7:1] == SLV_ADDR); rw = sh_s[0];
                ackit = sel; just_addr = 1'b1;
              end else begin
                if (sel && wn < 8) begin wlog[wn] = sh_s; wn++; end
                ackit = sel && (dn < int'(nak_at));
                dn++;
              end
            end
          end else if (cnt == 8) begin
            if (txm) begin macks = {macks[6:0], sda_line}; mlast = sda_line; end
            cnt = 9;
          end
        end
      end else if (in_xfer) begin
        if (cnt == 8) slv_low = txm ? 1'b0 : ackit;
        else if (cnt == 9) begin
          cnt = 0; slv_low = 1'b0;
          if (just_addr) begin
            if (sel && rw) begin txm = 1'b1; tidx = 0; end
          end else if (txm) begin
            if (mlast) txm = 1'b0; else tidx++;
          end
          just_addr = 1'b0;
          tb_byte = SLV_BASE + 8'(tidx);
          if (txm) slv_low = !tb_byte[7];
        end else if (txm && cnt >= 1 && cnt <= 7) slv_low = !tb_byte[7-cnt];
      end
      pscl = scl_o;
    end else if (sda_line !== psda && scl_o) begin
      if (!sda_line) begin
        starts++; if (in_xfer) reps++;
        in_xfer = 1'b1; cnt = 0; first = 1'b1; sel = 1'b0; txm = 1'b0;
        dn = 0; just_addr = 1'b0; slv_low = 1'b0;
      end else begin
        stops++; in_xfer = 1'b0; slv_low = 1'b0; txm = 1'b0;
      end
    end
    psda = sda_line;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(2'd3, s);
      if (!s[0]) return;
    end
  endtask

  function automatic logic [15:0] mk(input logic w, input logic two, input logic ao,
                                     input logic hold, input logic [6:0] a);
    return {2'b10, hold, ao, two, w, 2'b00, a, 1'b0};
  endfunction

  task automatic slv_clear(input logic [1:0] na);
    nak_at = na; wn = 0; macks = 8'd0;
    for (int i = 0; i < 8; i++) wlog[i] = 8'h00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R9 watchdog actual=hung expected=complete");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] s;
    logic [15:0] d;
    int st0;
    int sp0;
    int rp0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(scl_o === 1'b1, "R11 scl after reset", scl_o, 1);
    chk(sda_oe === 1'b0, "R11 sda after reset", sda_oe, 0);
    rd(2'd3, s);
    chk(s === 16'h0000, "R11 status after reset", s, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rn = 0;

    // table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      slv_clear(VT[v].nak_at);
      sp0 = stops;
      wr(2'd1, VT[v].wdat);
      wr(2'd0, mk(VT[v].wr, VT[v].two, VT[v].aonly, 1'b0, VT[v].addr));
      wait_idle();
      rd(2'd3, s);
      chk(s === {VT[v].exp_fl, 13'd0}, "R3/R4/R5/R6 status flags", s, {VT[v].exp_fl, 13'd0});
      chk(stops == sp0 + 1, "R6 one STOP per transaction", stops - sp0, 1);
      if (VT[v].wr) begin
        chk(wn == int'(VT[v].exp_sent), "R2 R3 bytes seen by slave", wn, VT[v].exp_sent);
        if (VT[v].exp_sent >= 1) chk(wlog[0] === VT[v].wdat[7:0], "R3 first byte", wlog[0], VT[v].wdat[7:0]);
        if (VT[v].exp_sent >= 2) chk(wlog[1] === VT[v].wdat[15:8], "R3 second byte", wlog[1], VT[v].wdat[15:8]);
      end else if (!VT[v].aonly) begin
        rd(2'd2, d);
        chk(d[7:0] === SLV_BASE, "R4 first read byte", d[7:0], SLV_BASE);
        if (VT[v].two) begin
          chk(d[15:8] === SLV_BASE + 8'd1, "R4 second read byte", d[15:8], SLV_BASE + 8'd1);
          chk(macks[1:0] === 2'b01, "R4 ack then nak", macks[1:0], 2'b01);
        end else begin
          chk(macks[0] === 1'b1, "R4 single byte nak", macks[0], 1);
        end
      end
      if (v == 0) chk(rise_t[2] - rise_t[1] == longint'(4 * DIV * 8), "R10 bit period",
                      rise_t[2] - rise_t[1], 4 * DIV * 8);
      wr(2'd3, 16'hE000);
    end

    // R1 non-native command ignored
    st0 = starts;
    wr(2'd0, 16'h40A0 | 16'h0400);
    repeat (60) @(negedge clk);
    rd(2'd3, s);
    chk(s === 16'h0000, "R1 non-native command ignored", s, 0);
    chk(starts == st0, "R1 no START for bad key", starts - st0, 0);

    // R9 command while busy ignored
    slv_clear(2'd3);
    st0 = starts;
    wr(2'd1, 16'h0011);
    wr(2'd0, mk(1'b1, 1'b0, 1'b0, 1'b0, SLV_ADDR));
    repeat (30) @(negedge clk);
    rd(2'd3, s);
    chk(s[0] === 1'b1, "R9 busy during transaction", s[0], 1);
    wr(2'd1, 16'h00FF);
    wr(2'd0, mk(1'b0, 1'b1, 1'b0, 1'b0, SLV_ADDR));
    wait_idle();
    repeat (200) @(negedge clk);
    rd(2'd3, s);
    chk(s === 16'h4000, "R9 only first command completes", s, 16'h4000);
    chk(wn == 1 && wlog[0] === 8'h11, "R9 slave saw first data only", wlog[0], 8'h11);
    chk(starts == st0 + 1, "R9 single START", starts - st0, 1);
    wr(2'd3, 16'hE000);

    // R7 hold then repeated START read; R8 selective clear
    slv_clear(2'd3);
    sp0 = stops; rp0 = reps;
    wr(2'd1, 16'h0007);
    wr(2'd0, mk(1'b1, 1'b0, 1'b0, 1'b1, SLV_ADDR));
    wait_idle();
    repeat (40) @(negedge clk);
    rd(2'd3, s);
    chk(s === 16'h4000, "R7 held write sets tx flag", s, 16'h4000);
    chk(scl_o === 1'b0, "R7 scl held low", scl_o, 0);
    chk(stops == sp0, "R7 no STOP while held", stops - sp0, 0);
    wr(2'd0, mk(1'b0, 1'b1, 1'b0, 1'b0, SLV_ADDR));
    wait_idle();
    chk(reps == rp0 + 1, "R7 repeated START seen", reps - rp0, 1);
    chk(stops == sp0 + 1, "R7 STOP after chained read", stops - sp0, 1);
    rd(2'd2, d);
    chk(d === {SLV_BASE + 8'd1, SLV_BASE}, "R7 chained read data", d, {SLV_BASE + 8'd1, SLV_BASE});
    chk(wlog[0] === 8'h07, "R7 register address byte", wlog[0], 8'h07);
    wr(2'd3, 16'h4000);
    rd(2'd3, s);
    chk(s === 16'h8000, "R8 clear of tx leaves rx", s, 16'h8000);
    wr(2'd3, 16'h8000);
    rd(2'd3, s);
    chk(s === 16'h0000, "R8 rx cleared", s, 0);

    // R8 set and clear in the same cycle: set wins
    slv_clear(2'd3);
    wr(2'd1, 16'h0055);
    wr(2'd0, mk(1'b1, 1'b0, 1'b0, 1'b0, SLV_ADDR));
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 16'h4000;
      #1;
      if (!reg_rdata[0]) break;
    end
    reg_we = 1'b0;
    rd(2'd3, s);
    chk(s[14] === 1'b1, "R8 set beats clear", s[14], 1);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule